// File: doc/BRIEF.md
# Register-Reference Instruction Execution Unit

This unit carries out the register-reference group of a small 16-bit accumulator machine. It holds an accumulator and a one-bit extension register. It takes each fetched instruction word over a valid/ready handshake. A legal word belongs to the group when its top nibble is `0111` and exactly one of its low twelve bits is set. The unit applies the selected accumulator or extension operation in a single clock. It also evaluates the conditional tests that let a program build branches out of an unconditional jump.

A skip whose condition holds produces a one-cycle `skip_pulse`, and the external program counter advances one extra word on it. The halt operation sets a sticky flag. While that flag is set the unit holds `instr_ready` low, so an upstream fetch stage stalls and no further word is accepted. A word is taken only in a cycle where both `instr_valid` and `instr_ready` are high. The producer keeps `instr_word` steady until that cycle. When `instr_valid` is low, nothing is consumed and no state moves. Memory-reference and I/O words, fetch and the program counter all live outside this unit.

Top module: `rri_exec`

## Requirements
- R1: After reset, `acc_q` is 0, `ext_q` is 0, `skip_pulse` is 0, `halted` is 0 and `instr_ready` is 1.
- R2: A word is accepted when `instr_valid` and `instr_ready` are both high. If its bits 15..12 are not `0111`, it changes neither register and raises no skip.
- R3: An accepted word with zero, two or more of bits 11..0 set changes neither register and raises no skip.
- R4: Bit 11 clears the accumulator (0x7800). Bit 10 clears the extension (0x7400). Bit 9 inverts every accumulator bit (0x7200). Bit 8 inverts the extension (0x7100).
- R5: Bit 6 rotates left through the extension (0x7040): the accumulator MSB goes to the extension and the extension goes to the accumulator LSB. Bit 7 rotates right (0x7080): the accumulator LSB goes to the extension and the extension goes to the accumulator MSB.
- R6: Bit 5 adds one to the accumulator modulo 2^16 and leaves the extension unchanged (0x7020).
- R7: Bits 4, 3, 2 and 1 (0x7010, 0x7008, 0x7004, 0x7002) test, in that order: accumulator MSB is 0, accumulator MSB is 1, accumulator is zero, extension is 0. Each test uses the values held before the instruction. When the test holds, `skip_pulse` is high for exactly the one cycle after the accepting edge.
- R8: Bit 0 (0x7001) sets `halted`. Only reset clears it. While it is set, `instr_ready` is 0 and words presented with `instr_valid` have no effect.
- R9: In a cycle without acceptance, both registers hold and `skip_pulse` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Unit can take a word (low once halted) |
| instr_word | input | 16 | Instruction word, held until accepted |
| acc_q | output | 16 | Accumulator |
| ext_q | output | 1 | Extension bit |
| skip_pulse | output | 1 | One-cycle request to skip the next word |
| halted | output | 1 | Sticky halt flag |

## Verification
The bench targets a zero accumulator, which satisfies both the zero test and the positive test. A design that treated zero as neither would drop one of those skips. Rotates are run with the extension set and with it clear, and across the MSB and LSB. A rotate that bypassed the extension would lose a bit or return the wrong one. Increment is taken through 0xFFFF to show both the wrap and the untouched extension. Words that fail the class check, words with two bits set and words with no bits set are all offered, and an unguarded decoder would apply a partial operation or a skip for them. After halt, words are still presented: a design that only latched the flag would keep executing them. A design that counted acceptance on `instr_valid` alone would alter state while idle or halted.

// File: rtl/rri_pkg.sv
package rri_pkg;

  localparam int unsigned INSTR_W  = 16;
  localparam int unsigned OP_COUNT = 12;
  localparam logic [3:0]  GROUP_TAG = 4'b0111;

  // select-bit positions in the low field
  localparam int unsigned SEL_HALT      = 0;
  localparam int unsigned SEL_SKIP_EXT0 = 1;
  localparam int unsigned SEL_SKIP_ZERO = 2;
  localparam int unsigned SEL_SKIP_NEG  = 3;
  localparam int unsigned SEL_SKIP_POS  = 4;
  localparam int unsigned SEL_ACC_INC   = 5;
  localparam int unsigned SEL_ROT_LEFT  = 6;
  localparam int unsigned SEL_ROT_RIGHT = 7;
  localparam int unsigned SEL_EXT_INV   = 8;
  localparam int unsigned SEL_ACC_INV   = 9;
  localparam int unsigned SEL_EXT_CLR   = 10;
  localparam int unsigned SEL_ACC_CLR   = 11;

  typedef logic [OP_COUNT-1:0] op_sel_t;

  typedef struct packed {
    logic acc_clr;
    logic ext_clr;
    logic acc_inv;
    logic ext_inv;
    logic rot_right;
    logic rot_left;
    logic acc_inc;
  } alu_ctl_t;

  typedef struct packed {
    logic if_pos;
    logic if_neg;
    logic if_zero;
    logic if_ext0;
  } skip_ctl_t;

endpackage

// File: rtl/rri_decode.sv
module rri_decode
  import rri_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output logic               legal,
  output alu_ctl_t           alu,
  output skip_ctl_t          skp,
  output logic               halt_req
);

  localparam int unsigned CNT_W = $clog2(OP_COUNT + 1);

  op_sel_t          sel;
  logic [CNT_W-1:0] ones;
  logic             in_group;

  assign sel      = word[OP_COUNT-1:0];
  assign in_group = (word[INSTR_W-1:INSTR_W-4] == GROUP_TAG);

  always_comb begin
    ones = '0;
    for (int i = 0; i < int'(OP_COUNT); i++) begin
      ones = ones + CNT_W'(sel[i]);
    end
  end

  assign legal = in_group && (ones == CNT_W'(1));

  always_comb begin
    alu      = '0;
    skp      = '0;
    halt_req = 1'b0;
    if (legal) begin
      alu.acc_clr   = sel[SEL_ACC_CLR];
      alu.ext_clr   = sel[SEL_EXT_CLR];
      alu.acc_inv   = sel[SEL_ACC_INV];
      alu.ext_inv   = sel[SEL_EXT_INV];
      alu.rot_right = sel[SEL_ROT_RIGHT];
      alu.rot_left  = sel[SEL_ROT_LEFT];
      alu.acc_inc   = sel[SEL_ACC_INC];
      skp.if_pos    = sel[SEL_SKIP_POS];
      skp.if_neg    = sel[SEL_SKIP_NEG];
      skp.if_zero   = sel[SEL_SKIP_ZERO];
      skp.if_ext0   = sel[SEL_SKIP_EXT0];
      halt_req      = sel[SEL_HALT];
    end
  end

endmodule

// File: rtl/rri_datapath.sv
module rri_datapath
  import rri_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc,
  input  logic              ext,
  input  alu_ctl_t          ctl,
  output logic [DATA_W-1:0] acc_nxt,
  output logic              ext_nxt
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    acc_nxt = acc;
    ext_nxt = ext;
    if (ctl.acc_clr) begin
      acc_nxt = '0;
    end else if (ctl.ext_clr) begin
      ext_nxt = 1'b0;
    end else if (ctl.acc_inv) begin
      acc_nxt = ~acc;
    end else if (ctl.ext_inv) begin
      ext_nxt = ~ext;
    end else if (ctl.rot_right) begin
      acc_nxt = {ext, acc[DATA_W-1:1]};
      ext_nxt = acc[0];
    end else if (ctl.rot_left) begin
      acc_nxt = {acc[DATA_W-2:0], ext};
      ext_nxt = acc[DATA_W-1];
    end else if (ctl.acc_inc) begin
      acc_nxt = acc + ONE;
    end
  end

endmodule

// File: rtl/rri_skip_eval.sv
module rri_skip_eval
  import rri_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc,
  input  logic              ext,
  input  skip_ctl_t         ctl,
  output logic              take
);

  logic sign_bit;
  logic is_zero;

  assign sign_bit = acc[DATA_W-1];
  assign is_zero  = (acc == '0);

  assign take = (ctl.if_pos  && !sign_bit) ||
                (ctl.if_neg  &&  sign_bit) ||
                (ctl.if_zero &&  is_zero)  ||
                (ctl.if_ext0 && !ext);

endmodule

// File: rtl/rri_exec.sv
module rri_exec
  import rri_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [INSTR_W-1:0] instr_word,
  output logic [DATA_W-1:0]  acc_q,
  output logic               ext_q,
  output logic               skip_pulse,
  output logic               halted
);

  logic              take_word;
  logic              legal;
  alu_ctl_t          alu_ctl;
  skip_ctl_t         skip_ctl;
  logic              halt_req;
  logic [DATA_W-1:0] acc_nxt;
  logic              ext_nxt;
  logic              skip_cond;

  assign instr_ready = !halted;
  assign take_word   = instr_valid && instr_ready;

  rri_decode u_decode (
    .word     (instr_word),
    .legal    (legal),
    .alu      (alu_ctl),
    .skp      (skip_ctl),
    .halt_req (halt_req)
  );

  rri_datapath #(.DATA_W(DATA_W)) u_datapath (
    .acc     (acc_q),
    .ext     (ext_q),
    .ctl     (alu_ctl),
    .acc_nxt (acc_nxt),
    .ext_nxt (ext_nxt)
  );

  rri_skip_eval #(.DATA_W(DATA_W)) u_skip (
    .acc  (acc_q),
    .ext  (ext_q),
    .ctl  (skip_ctl),
    .take (skip_cond)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= '0;
      ext_q      <= 1'b0;
      skip_pulse <= 1'b0;
      halted     <= 1'b0;
    end else begin
      skip_pulse <= take_word && legal && skip_cond;
      if (take_word && legal) begin
        acc_q <= acc_nxt;
        ext_q <= ext_nxt;
        if (halt_req) begin
          halted <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rri_exec_chk.sv
module rri_exec_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic              instr_ready,
  input logic [15:0]       instr_word,
  input logic [DATA_W-1:0] acc_q,
  input logic              ext_q,
  input logic              skip_pulse,
  input logic              halted
);

  logic acc_take;
  assign acc_take = instr_valid && instr_ready;

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_take |=> ($stable(acc_q) && $stable(ext_q) && !skip_pulse));

  assert_class_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_take && instr_word[15:12] != 4'h7) |=> ($stable(acc_q) && $stable(ext_q) && !skip_pulse));

  assert_nonhot_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_take && !$onehot(instr_word[11:0])) |=> ($stable(acc_q) && $stable(ext_q) && !skip_pulse));

  assert_clear_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_take && instr_word == 16'h7800) |=> (acc_q == '0));

  assert_rot_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_take && instr_word == 16'h7080) |=> (ext_q == $past(acc_q[0])));

  assert_inc_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_take && instr_word == 16'h7020) |=>
      ((acc_q == ($past(acc_q) + {{(DATA_W-1){1'b0}}, 1'b1})) && $stable(ext_q)));

  assert_skip_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    skip_pulse |-> $past(acc_take));

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && instr_valid) |=> ($stable(acc_q) && $stable(ext_q) && !skip_pulse));

endmodule

bind rri_exec rri_exec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr_ready (instr_ready),
  .instr_word  (instr_word),
  .acc_q       (acc_q),
  .ext_q       (ext_q),
  .skip_pulse  (skip_pulse),
  .halted      (halted)
);

// File: tb/rri_exec_test.sv
`timescale 1ns/1ps
module rri_exec_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [15:0] instr_word = 16'h0000;
  logic [15:0] acc_q;
  logic        ext_q;
  logic        skip_pulse;
  logic        halted;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  rri_exec uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready),
    .instr_word  (instr_word),
    .acc_q       (acc_q),
    .ext_q       (ext_q),
    .skip_pulse  (skip_pulse),
    .halted      (halted)
  );

  // word, expected acc, ext, skip, halted after the step
  localparam int NVEC = 25;
  localparam logic [34:0] VEC [NVEC] = '{
    {16'h7004, 16'h0000, 1'b0, 1'b1, 1'b0},
    {16'h7010, 16'h0000, 1'b0, 1'b1, 1'b0},
    {16'h7008, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'h7002, 16'h0000, 1'b0, 1'b1, 1'b0},
    {16'h7100, 16'h0000, 1'b1, 1'b0, 1'b0},
    {16'h7002, 16'h0000, 1'b1, 1'b0, 1'b0},
    {16'h7080, 16'h8000, 1'b0, 1'b0, 1'b0},
    {16'h7008, 16'h8000, 1'b0, 1'b1, 1'b0},
    {16'h7010, 16'h8000, 1'b0, 1'b0, 1'b0},
    {16'h7004, 16'h8000, 1'b0, 1'b0, 1'b0},
    {16'h7040, 16'h0000, 1'b1, 1'b0, 1'b0},
    {16'h7040, 16'h0001, 1'b0, 1'b0, 1'b0},
    {16'h7200, 16'hFFFE, 1'b0, 1'b0, 1'b0},
    {16'h7020, 16'hFFFF, 1'b0, 1'b0, 1'b0},
    {16'h7020, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'h7200, 16'hFFFF, 1'b0, 1'b0, 1'b0},
    {16'h7080, 16'h7FFF, 1'b1, 1'b0, 1'b0},
    {16'h7400, 16'h7FFF, 1'b0, 1'b0, 1'b0},
    {16'h7800, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'h7021, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'hF004, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'h6004, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'h7000, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'h7100, 16'h0000, 1'b1, 1'b0, 1'b0},
    {16'h7001, 16'h0000, 1'b1, 1'b0, 1'b1}
  };

  function automatic string tag_of(input logic [15:0] w);
    if (w[15:12] != 4'h7) return "R2";
    if (!$onehot(w[11:0])) return "R3";
    if (w[0]) return "R8";
    if (|w[4:1]) return "R7";
    if (w[5]) return "R6";
    if (|w[7:6]) return "R5";
    return "R4";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] w);
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = w;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic expect_state(input string req, input logic [15:0] a, input logic e,
                              input logic s, input logic h);
    chk(req, {11'd0, acc_q, ext_q, skip_pulse, halted, instr_ready},
             {11'd0, a, e, s, h, ~h});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_state("R1", 16'h0000, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][34:19]);
      expect_state(tag_of(VEC[i][34:19]), VEC[i][18:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R8: words offered while halted are not taken
    step(16'h7400);
    expect_state("R8", 16'h0000, 1'b1, 1'b0, 1'b1);
    step(16'h7004);
    expect_state("R8", 16'h0000, 1'b1, 1'b0, 1'b1);

    // R1: reset clears halt and registers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    expect_state("R1", 16'h0000, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;

    // R9: word present without valid is not consumed
    step(16'h7200);
    expect_state("R4", 16'hFFFF, 1'b0, 1'b0, 1'b0);
    instr_word = 16'h7800;
    repeat (2) @(negedge clk);
    expect_state("R9", 16'hFFFF, 1'b0, 1'b0, 1'b0);

    // R7: skip pulse lasts one cycle only
    step(16'h7800);
    step(16'h7004);
    expect_state("R7", 16'h0000, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    expect_state("R7", 16'h0000, 1'b0, 1'b0, 1'b0);

    // R5: left rotate carries MSB into ext with ext returning at LSB
    step(16'h7200);
    step(16'h7040);
    expect_state("R5", 16'hFFFE, 1'b1, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule